// File: doc/BRIEF.md
# CRC Error Resynchronization Monitor

This block sits beside an E1 receive framer and watches the CRC-4 error strobe that fires once per checked submultiframe. While the receiver holds multiframe alignment, each strobe adds one to an error count. When more than a fixed number of errors (914 by default) build up inside one second, the block raises a one-cycle request. The request tells the framer to drop alignment and search again for both the basic frame and the multiframe.

The one-second window is built from a 1 ms enable tick. After a set number of ticks (1000 by default), the error count returns to zero and a new window opens. Gaining multiframe alignment also clears the count and restarts the window, so every fresh alignment begins with a full second and no errors. An enable input suppresses the request. Counting goes on while it is low, so the count can still be observed.

Top module: `crc_resync_mon`

## Requirements
- R1: After reset, `err_count` is 0 and `resync_req` is low.
- R2: While `mf_sync` is high, each cycle with `crc_err` high raises `err_count` by exactly one, and the new value is visible in the following cycle.
- R3: A `crc_err` strobe while `mf_sync` is low leaves `err_count` unchanged.
- R4: The error that takes the count from THRESHOLD (914) to THRESHOLD+1 produces `resync_req` high for exactly one cycle. The pulse appears in the same cycle in which `err_count` first reads THRESHOLD+1.
- R5: `err_count` saturates at THRESHOLD+1. Further errors neither change it nor raise `resync_req` until the count is cleared.
- R6: After the WIN_TICKS-th `tick_ms` since the window started, `err_count` reads 0 in the next cycle and a new window begins. An error in the same cycle as that tick is discarded.
- R7: A rising edge of `mf_sync` clears `err_count` and restarts the tick window from zero. An error in the cycle of the edge is discarded. A level that is high out of reset counts as a rising edge in its first cycle.
- R8: While `enable` is low, `resync_req` stays low. Counting, saturation and window clearing behave exactly as when `enable` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows the resynchronization request |
| mf_sync | input | 1 | Receiver is in multiframe-synchronous state |
| crc_err | input | 1 | One-cycle CRC-4 error strobe |
| tick_ms | input | 1 | One-cycle 1 ms time base strobe |
| resync_req | output | 1 | One-cycle request for a new frame and multiframe search |
| err_count | output | CNT_W | Errors counted in the current window |

## Verification
The assertions assume that `crc_err` and `tick_ms` are plain single-cycle strobes that may arrive in any cycle, including together and in the cycle of an alignment edge. They also assume that `mf_sync` and `enable` are synchronous levels. The stimulus changes every input only at the falling clock edge. It mixes back-to-back error bursts, long tick runs that close the window exactly at its boundary, and pseudo-random patterns that land strobes on alignment edges and window ends. These cover the orderings the clear priority has to resolve.

// File: rtl/crm_pkg.sv
package crm_pkg;
  localparam int unsigned DEF_THRESHOLD = 914;
  localparam int unsigned DEF_WIN_TICKS = 1000;
  localparam int unsigned DEF_CNT_W     = 10;

  // reason the error counter was cleared this cycle
  typedef enum logic [1:0] {
    CLR_NONE = 2'd0,
    CLR_SYNC = 2'd1,
    CLR_WIN  = 2'd2
  } clr_cause_e;
endpackage

// File: rtl/crm_edge.sv
module crm_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;

  // R7
  rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/crm_window.sv
module crm_window #(
  parameter int unsigned WIN_TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic win_end
);
  localparam int unsigned TW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(WIN_TICKS - 1);

  logic [TW-1:0] tick_cnt;

  assign win_end = tick & ~restart & (tick_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)       tick_cnt <= '0;
    else if (restart) tick_cnt <= '0;
    else if (tick)    tick_cnt <= win_end ? '0 : tick_cnt + 1'b1;
  end

  // R6
  tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_cnt <= LAST);

  // R6
  win_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> tick_cnt == '0);

  // R7
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> tick_cnt == '0);
endmodule

// File: rtl/crm_err_counter.sv
module crm_err_counter
  import crm_pkg::*;
#(
  parameter int unsigned THRESHOLD = 914,
  parameter int unsigned CNT_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             in_sync,
  input  logic             crc_err,
  input  logic             clr_sync,
  input  logic             clr_win,
  output logic [CNT_W-1:0] count,
  output logic             req
);
  localparam logic [CNT_W-1:0] THR_V = CNT_W'(THRESHOLD);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(THRESHOLD + 1);

  clr_cause_e cause;
  logic       bump;

  always_comb begin
    if (clr_sync)     cause = CLR_SYNC;
    else if (clr_win) cause = CLR_WIN;
    else              cause = CLR_NONE;
  end

  assign bump = crc_err & in_sync & (cause == CLR_NONE) & (count != SAT_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      req   <= 1'b0;
    end else begin
      req <= enable & bump & (count == THR_V);
      if (cause != CLR_NONE) count <= '0;
      else if (bump)         count <= count + 1'b1;
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= SAT_V);

  // R3
  hold_unsynced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_sync && !clr_sync && !clr_win) |=> $stable(count));

  // R7
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sync |=> count == '0);

  // R4
  req_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> (count == SAT_V && $past(count) == THR_V));

  // R8
  no_req_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !req);
endmodule

// File: rtl/crc_resync_mon.sv
module crc_resync_mon
  import crm_pkg::*;
#(
  parameter int unsigned THRESHOLD = DEF_THRESHOLD,
  parameter int unsigned WIN_TICKS = DEF_WIN_TICKS,
  parameter int unsigned CNT_W     = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             mf_sync,
  input  logic             crc_err,
  input  logic             tick_ms,
  output logic             resync_req,
  output logic [CNT_W-1:0] err_count
);
  logic sync_rise;
  logic win_end;

  crm_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (mf_sync),
    .rise  (sync_rise)
  );

  crm_window #(.WIN_TICKS(WIN_TICKS)) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (sync_rise),
    .tick    (tick_ms),
    .win_end (win_end)
  );

  crm_err_counter #(.THRESHOLD(THRESHOLD), .CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .in_sync  (mf_sync),
    .crc_err  (crc_err),
    .clr_sync (sync_rise),
    .clr_win  (win_end),
    .count    (err_count),
    .req      (resync_req)
  );

  // R4
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync_req |=> !resync_req);

  // R6
  win_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> err_count == '0);
endmodule

// File: tb/crc_resync_mon_bench.sv
module crc_resync_mon_bench;
  localparam int CLK_PERIOD = 10;
  localparam int THR   = 914;
  localparam int WIN   = 1000;
  localparam int CW    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, mf_sync = 1'b0, crc_err = 1'b0, tick_ms = 1'b0;
  logic resync_req;
  logic [CW-1:0] err_count;

  int n_checks = 0;
  int n_errs = 0;
  int cycles = 0;
  int req_seen = 0;

  // requirement model state
  int  m_cnt = 0, m_ticks = 0;
  bit  m_prev = 0, m_req = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_resync_mon #(.THRESHOLD(THR), .WIN_TICKS(WIN), .CNT_W(CW)) u_crc_resync_mon (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mf_sync(mf_sync),
    .crc_err(crc_err), .tick_ms(tick_ms),
    .resync_req(resync_req), .err_count(err_count)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  // one clock with given inputs; model updated from the requirements
  task automatic step(input bit en, input bit sy, input bit er, input bit tk,
                      input string tag);
    bit rise, wend;
    @(negedge clk);
    enable = en; mf_sync = sy; crc_err = er; tick_ms = tk;
    @(posedge clk);
    cycles++;
    rise = sy && !m_prev;                      // R7
    m_prev = sy;
    wend = !rise && tk && (m_ticks == WIN-1);  // R6
    m_req = en && er && sy && !rise && !wend && (m_cnt == THR); // R4 R8
    if (rise) m_ticks = 0;
    else if (tk) m_ticks = wend ? 0 : m_ticks + 1;
    if (rise || wend) m_cnt = 0;
    else if (er && sy && m_cnt < THR+1) m_cnt++;  // R2 R3 R5
    #1;
    if (resync_req) req_seen++;
    check({tag, " count"}, int'(err_count), m_cnt);
    check({tag, " req"}, int'(resync_req), int'(m_req));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 150000) begin
        n_errs++; n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    check("R1 count", int'(err_count), 0);
    check("R1 req", int'(resync_req), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: burst of errors in sync (first cycle is the rising edge)
    step(1, 1, 0, 0, "R7");
    for (int i = 0; i < 10; i++) step(1, 1, 1, 0, "R2");
    check("R2 ten", int'(err_count), 10);

    // R3: errors out of sync ignored
    for (int i = 0; i < 5; i++) step(1, 0, 1, 0, "R3");
    check("R3 held", int'(err_count), 10);

    // R7: edge with coincident error clears
    step(1, 1, 1, 0, "R7");
    check("R7 clear", int'(err_count), 0);

    // R4/R5: exceed the threshold, then keep going
    req_seen = 0;
    for (int i = 1; i <= THR+1; i++) begin
      step(1, 1, 1, 0, "R4");
      if (i == THR) check("R4 before", int'(resync_req), 0);
      if (i == THR+1) check("R4 fire", int'(resync_req), 1);
    end
    for (int i = 0; i < 20; i++) step(1, 1, 1, 0, "R5");
    check("R5 sat", int'(err_count), THR+1);
    check("R5 single pulse", req_seen, 1);

    // R6: window boundary, error on closing tick discarded
    for (int i = 0; i < WIN-1; i++) step(1, 1, 0, 1, "R6");
    check("R6 before end", int'(err_count), THR+1);
    step(1, 1, 1, 1, "R6");
    check("R6 cleared", int'(err_count), 0);

    // R8: disabled, full count but no request
    req_seen = 0;
    for (int i = 0; i < THR+5; i++) step(0, 1, 1, 0, "R8");
    check("R8 sat", int'(err_count), THR+1);
    check("R8 no req", req_seen, 0);
    for (int i = 0; i < WIN; i++) step(0, 1, 0, 1, "R8");
    check("R8 window", int'(err_count), 0);

    // mixed sweeps: error density and tick rate vary per pass
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 9000; i++) begin
        bit er, tk, sy, en;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        er = (p == 0) ? 1'b1 : (lfsr[3:0] > 4'(p * 3));
        tk = (p < 2) ? (lfsr[7:5] == 3'd0) : lfsr[8];
        sy = !(lfsr[15:9] == 7'd0);
        en = (p != 3) || lfsr[11];
        step(en, sy, er, tk, "R6 R7 sweep");
      end
    end

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule